// File: doc/BRIEF.md
# Programmable Input Debounce Filter

The block filters a bank of interrupt input lines before they reach the interrupt latching logic. The lower `DB_CNT` lines each have their own filter. An enabled filter holds its output at the last accepted level. It accepts a new input level only after that level has held without a break for a programmed number of time-base ticks. The time base is a free-running prescaler that produces one tick every `PRESCALE` clock cycles. Each line is first brought into the clock domain by a two-flop synchroniser.

Every filtered channel owns one 8-bit configuration field, and four fields share each 32-bit word. Software reaches the words through three address windows of a simple write-strobe register bus: a direct view, a view where writing 1 sets bits, and a view where writing 1 clears bits. A counter-restart bit lets software restart a channel's stability count after it has serviced an interrupt, without turning the filter off. The neighbouring logic supplies each line's sensing mode. The filter acts only on lines sensed by level; lines sensed by edge pass straight through.

Top module: `irq_debounce`

## Requirements
- R1: Field layout: channel n uses bits [8*(n%4)+7 : 8*(n%4)] of word n/4. Within a field, bit 0 is enable, bit 1 is counter restart and bits 6:4 are the time code; bits 2, 3 and 7 always read 0. The direct view is at byte offset 0x500 with words at a 4-byte stride. A write there replaces the whole field, and a read there returns the word.
- R2: A write to the window at 0x600 ORs the write data into the fields. A write to the window at 0x700 clears every field bit that is 1 in the write data. Reads from either window return the same word as the direct view.
- R3: Fields of channels with index DB_CNT or above read as 0, and writes to them are ignored. The outputs of those channels follow the synchronised input as if unfiltered. Addresses outside the three windows read as 0.
- R4: For an enabled channel in level mode, a changed input reaches the output only after the input has held the new level for the full selected time. A shorter excursion leaves the output unchanged and clears the count.
- R5: Time codes 0 to 6 select 1, 2, 32, 64, 128, 256 and 512 ticks; code 7 selects 512 ticks. One tick is PRESCALE clock cycles.
- R6: A channel whose level_mode_i bit is 0 (edge sensing) bypasses the filter. Its output follows the input three clock edges later.
- R7: A channel with enable 0 bypasses the filter in the same way.
- R8: The restart bit clears the channel's count and reads back as 0 by the second clock edge after the write. A write of 1 through the set window, with enable kept set, restarts the stability time from that point.
- R9: After reset, all fields read 0 and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| irq_in_i | input | NUM_IN | Raw interrupt lines |
| level_mode_i | input | NUM_IN | 1 = line sensed by level, 0 = by edge |
| irq_flt_o | output | NUM_IN | Filtered lines |

## Verification
The bench builds the block with NUM_IN=8, DB_CNT=6 and PRESCALE=2. With these values the second word holds two live fields and two dead fields, so the ignored-write rule can be checked at the ports. The short tick also keeps the 512-tick code within a few thousand cycles. That lets the bench tell code 7 apart from both a shorter and a longer time, and lets it place a counter restart in the middle of a 32-tick window.

// File: rtl/irq_debounce_pkg.sv
package irq_debounce_pkg;
  localparam int TERM_W = 10;
  localparam logic [7:0] FLD_MASK  = 8'h73;
  localparam logic [7:0] FLD_RST_M = 8'h02;

  typedef struct packed {
    logic [2:0] sel;
    logic       rst;
    logic       en;
  } dbc_cfg_t;

  typedef enum logic [1:0] {V_NONE, V_CTRL, V_SET, V_CLR} view_e;

  function automatic logic [TERM_W-1:0] sel_ticks(input logic [2:0] code);
    case (code)
      3'd0:    return TERM_W'(1);
      3'd1:    return TERM_W'(2);
      3'd2:    return TERM_W'(32);
      3'd3:    return TERM_W'(64);
      3'd4:    return TERM_W'(128);
      3'd5:    return TERM_W'(256);
      default: return TERM_W'(512);
    endcase
  endfunction
endpackage

// File: rtl/irq_debounce_prescaler.sv
module irq_debounce_prescaler #(
  parameter int PRESCALE = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + CW'(1);
  end

  assign tick_o = (cnt_q == LAST);

  // R5
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> ((PRESCALE == 1) || !tick_o));
endmodule

// File: rtl/irq_debounce_regs.sv
module irq_debounce_regs
  import irq_debounce_pkg::*;
#(
  parameter int DB_CNT   = 8,
  parameter int ADDR_W   = 12,
  parameter int CTRL_OFF = 'h500,
  parameter int SET_OFF  = 'h600,
  parameter int CLR_OFF  = 'h700
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output dbc_cfg_t          cfg_o [DB_CNT]
);
  localparam int NUM_W = (DB_CNT + 3) / 4;
  localparam int SPAN  = 4 * NUM_W;

  function automatic logic hit_f(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] base);
    logic [ADDR_W-1:0] r;
    r = a - base;
    return (a >= base) && (r < ADDR_W'(SPAN)) && (r[1:0] == 2'b00);
  endfunction

  view_e             view;
  logic [ADDR_W-3:0] widx;
  logic [ADDR_W-1:0] rel_c, rel_s, rel_k;
  logic [DB_CNT*8-1:0] fld_all;

  always_comb begin
    rel_c = reg_addr_i - ADDR_W'(CTRL_OFF);
    rel_s = reg_addr_i - ADDR_W'(SET_OFF);
    rel_k = reg_addr_i - ADDR_W'(CLR_OFF);
    view  = V_NONE;
    widx  = '0;
    if (hit_f(reg_addr_i, ADDR_W'(CTRL_OFF))) begin
      view = V_CTRL; widx = rel_c[ADDR_W-1:2];
    end else if (hit_f(reg_addr_i, ADDR_W'(SET_OFF))) begin
      view = V_SET;  widx = rel_s[ADDR_W-1:2];
    end else if (hit_f(reg_addr_i, ADDR_W'(CLR_OFF))) begin
      view = V_CLR;  widx = rel_k[ADDR_W-1:2];
    end
  end

  for (genvar i = 0; i < DB_CNT; i++) begin : g_fld
    localparam int WI = i / 4;
    localparam int SH = 8 * (i % 4);
    logic [7:0] fld_q, wb, base, nxt;

    always_comb begin
      wb   = reg_wdata_i[SH +: 8] & FLD_MASK;
      base = fld_q & ~FLD_RST_M;   // restart bit self-clears
      nxt  = base;
      if (reg_we_i && (widx == (ADDR_W-2)'(WI))) begin
        case (view)
          V_CTRL:  nxt = wb;
          V_SET:   nxt = base | wb;
          V_CLR:   nxt = base & ~wb;
          default: nxt = base;
        endcase
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fld_q <= '0;
      else         fld_q <= nxt;
    end

    assign fld_all[8*i +: 8] = fld_q;
    assign cfg_o[i] = '{sel: fld_q[6:4], rst: fld_q[1], en: fld_q[0]};

    // R8
    rst_self_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fld_q[1] && !reg_we_i) |=> !fld_q[1]);
    // R1
    rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fld_q & ~FLD_MASK) == 8'h00);
  end

  always_comb begin
    reg_rdata_o = '0;
    if (view != V_NONE) begin
      for (int j = 0; j < DB_CNT; j++) begin
        if (widx == (ADDR_W-2)'(j / 4)) reg_rdata_o[8*(j%4) +: 8] = fld_all[8*j +: 8];
      end
    end
  end
endmodule

// File: rtl/irq_debounce_chan.sv
module irq_debounce_chan
  import irq_debounce_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       in_i,
  input  logic       flt_en_i,
  input  logic [2:0] sel_i,
  input  logic       cnt_rst_i,
  output logic       out_o
);
  logic [1:0]        sync_q;
  logic              lvl;
  logic              out_q;
  logic [TERM_W-1:0] cnt_q;
  logic [TERM_W-1:0] term;

  assign lvl  = sync_q[1];
  assign term = sel_ticks(sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[0], in_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= 1'b0;
      cnt_q <= '0;
    end else if (!flt_en_i) begin
      out_q <= lvl;
      cnt_q <= '0;
    end else if (cnt_rst_i || (lvl == out_q)) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if ({1'b0, cnt_q} + 1'b1 >= {1'b0, term}) begin
        out_q <= lvl;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign out_o = out_q;

  // R4
  eq_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_en_i && (lvl == out_q)) |=> (cnt_q == '0));
  // R4
  moves_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_en_i && !tick_i) |=> $stable(out_q));
  // R8
  cnt_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_rst_i |=> (cnt_q == '0));
  // R6
  bypass_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flt_en_i |=> (out_q == $past(lvl)));
endmodule

// File: rtl/irq_debounce.sv
module irq_debounce
  import irq_debounce_pkg::*;
#(
  parameter int NUM_IN   = 12,
  parameter int DB_CNT   = 8,
  parameter int PRESCALE = 100,
  parameter int ADDR_W   = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [NUM_IN-1:0] irq_in_i,
  input  logic [NUM_IN-1:0] level_mode_i,
  output logic [NUM_IN-1:0] irq_flt_o
);
  logic     tick;
  dbc_cfg_t cfg [DB_CNT];

  irq_debounce_prescaler #(.PRESCALE(PRESCALE)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  irq_debounce_regs #(.DB_CNT(DB_CNT), .ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .cfg_o      (cfg)
  );

  for (genvar i = 0; i < NUM_IN; i++) begin : g_ch
    logic       f_en, f_rst;
    logic [2:0] f_sel;
    if (i < DB_CNT) begin : g_flt
      assign f_en  = cfg[i].en & level_mode_i[i];
      assign f_sel = cfg[i].sel;
      assign f_rst = cfg[i].rst;
    end else begin : g_raw
      assign f_en  = 1'b0;
      assign f_sel = 3'd0;
      assign f_rst = 1'b0;
    end

    irq_debounce_chan u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .in_i     (irq_in_i[i]),
      .flt_en_i (f_en),
      .sel_i    (f_sel),
      .cnt_rst_i(f_rst),
      .out_o    (irq_flt_o[i])
    );
  end
endmodule

// File: tb/irq_debounce_bench.sv
module irq_debounce_bench;
  localparam int NUM_IN = 8;
  localparam int DB_CNT = 6;
  localparam int PRESC  = 2;
  localparam int ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NUM_IN-1:0] din = '0;
  logic [NUM_IN-1:0] lvl = '0;
  logic [NUM_IN-1:0] dout;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  irq_debounce #(.NUM_IN(NUM_IN), .DB_CNT(DB_CNT), .PRESCALE(PRESC), .ADDR_W(ADDR_W)) u_irq_debounce (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_in_i(din),
    .level_mode_i(lvl), .irq_flt_o(dout)
  );

  typedef struct packed {
    logic [3:0]  ch;
    logic        en;
    logic [2:0]  code;
    logic        lv;
    logic [11:0] hold;
    logic        exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{ch: 4'd0, en: 1'b1, code: 3'd0, lv: 1'b1, hold: 12'd8,    exp: 1'b1},
    '{ch: 4'd1, en: 1'b1, code: 3'd2, lv: 1'b1, hold: 12'd40,   exp: 1'b0},
    '{ch: 4'd1, en: 1'b1, code: 3'd2, lv: 1'b1, hold: 12'd80,   exp: 1'b1},
    '{ch: 4'd2, en: 1'b1, code: 3'd3, lv: 1'b1, hold: 12'd100,  exp: 1'b0},
    '{ch: 4'd2, en: 1'b1, code: 3'd3, lv: 1'b1, hold: 12'd140,  exp: 1'b1},
    '{ch: 4'd3, en: 1'b1, code: 3'd2, lv: 1'b0, hold: 12'd4,    exp: 1'b1},
    '{ch: 4'd4, en: 1'b0, code: 3'd6, lv: 1'b1, hold: 12'd4,    exp: 1'b1},
    '{ch: 4'd5, en: 1'b1, code: 3'd7, lv: 1'b1, hold: 12'd1000, exp: 1'b0},
    '{ch: 4'd5, en: 1'b1, code: 3'd7, lv: 1'b1, hold: 12'd1040, exp: 1'b1},
    '{ch: 4'd6, en: 1'b1, code: 3'd6, lv: 1'b1, hold: 12'd4,    exp: 1'b1},
    '{ch: 4'd3, en: 1'b1, code: 3'd1, lv: 1'b1, hold: 12'd2,    exp: 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    addr = ADDR_W'(a); wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = ADDR_W'(a);
    #1 d = rdata;
  endtask

  task automatic setup_ch(input int ch, input logic en, input logic [2:0] code);
    int sh;
    sh = 8 * (ch % 4);
    wr('h700 + 4 * (ch / 4), 32'hFF << sh);
    wr('h600 + 4 * (ch / 4), {24'd0, 1'b0, code, 3'b000, en} << sh);
  endtask

  logic [31:0] r;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    chk("R9 out", {24'd0, dout}, 32'h0);
    rd('h500, r); chk("R9 word0", r, 32'h0);
    rd('h504, r); chk("R9 word1", r, 32'h0);

    // R1 direct view, reserved bits, restart bit gone by second edge
    wr('h500, 32'hFFFF_FFFF);
    @(negedge clk);
    rd('h500, r); chk("R1 word0", r, 32'h7171_7171);
    // R3 dead fields in word1
    wr('h504, 32'hFFFF_FFFF);
    @(negedge clk);
    rd('h504, r); chk("R3 word1", r, 32'h0000_7171);
    rd('h508, r); chk("R3 beyond", r, 32'h0);
    rd('h400, r); chk("R3 outside", r, 32'h0);
    // R2 clear and set windows
    wr('h700, 32'h0000_F000);
    rd('h500, r); chk("R2 clr", r, 32'h7171_0171);
    wr('h600, 32'h0000_2000);
    rd('h500, r); chk("R2 set", r, 32'h7171_2171);
    rd('h600, r); chk("R2 set view read", r, 32'h7171_2171);
    rd('h704, r); chk("R2 clr view read", r, 32'h0000_7171);
    wr('h500, 32'h0);
    wr('h504, 32'h0);

    // table walk: R4/R5 timing, R6 edge bypass, R7 disabled, R3 unfiltered
    for (int v = 0; v < NV; v++) begin
      int c;
      string tag;
      c = int'(VEC[v].ch);
      if (c >= DB_CNT)   tag = "R3 vec";
      else if (!VEC[v].lv) tag = "R6 vec";
      else if (!VEC[v].en) tag = "R7 vec";
      else               tag = "R4/R5 vec";
      setup_ch(c, VEC[v].en, VEC[v].code);
      lvl = '0; lvl[c] = VEC[v].lv;
      repeat (4) @(negedge clk);
      din[c] = 1'b1;
      repeat (int'(VEC[v].hold)) @(negedge clk);
      chk(tag, {31'd0, dout[c]}, {31'd0, VEC[v].exp});
      din[c] = 1'b0;
      repeat (1200) @(negedge clk);
      chk("R4 settle", {31'd0, dout[c]}, 32'h0);
    end

    // R8 restart mid-window on ch0, code 2 (32 ticks)
    lvl = '0; lvl[0] = 1'b1;
    setup_ch(0, 1'b1, 3'd2);
    repeat (4) @(negedge clk);
    din[0] = 1'b1;
    repeat (40) @(negedge clk);
    wr('h600, 32'h0000_0002);
    @(negedge clk);
    rd('h500, r); chk("R8 restart bit cleared", r & 32'hFF, 32'h21);
    repeat (48) @(negedge clk);
    chk("R8 held after restart", {31'd0, dout[0]}, 32'h0);
    repeat (30) @(negedge clk);
    chk("R8 passes after full time", {31'd0, dout[0]}, 32'h1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule